// File: doc/BRIEF.md
# Windowed Register File Controller

This block is a register file that gives each procedure its own window of registers. Each window has three groups of eight: parameters, locals and temporaries. The windows sit on a circular physical array, and neighbouring windows overlap. A caller's temporary group is therefore the same set of physical registers as its callee's parameter group, so arguments and results cross a call without being copied. Alongside the ring sits a bank of eight global registers that every window sees unchanged.

Software addresses registers with 5-bit window-relative numbers through two read ports and one write port. A call moves the current-window pointer one window forward and a return moves it one back. A ring of N windows holds at most N-1 live activations. A call made at that limit first has the block ask an external sequencer to save the oldest activation's parameters and locals, one register per handshake beat. A return made with only one activation resident, while saved activations remain, has the block ask for the caller's window to be restored the same way. Both transfers finish on their own and then complete the pending call or return. The number of windows must be a power of two.

Top module: `winreg_file`

## Requirements
- R1: Logical registers 0 to 7 address the global bank; a value written there reads back the same from every window, whatever calls and returns happen in between.
- R2: Logical register n in 8..31 addresses physical ring entry (16·cwp + n − 8) mod (16·N): 8..15 are parameters, 16..23 locals, 24..31 temporaries. A caller's register 24+k is its callee's register 8+k.
- R3: A caller's locals (16..23) are untouched by the callee and read back their old values after the return.
- R4: Read data appears on the clock edge after the register number is presented. A write to the same register in that cycle is not yet visible; the new value appears on the following read.
- R5: After reset the window pointer is 0, one activation is resident, none are saved, and busy, spill request and fill request are all low.
- R6: A call with fewer than N−1 resident activations advances the window pointer by one at the next edge. A return with more than one resident activation moves it back by one.
- R7: A call with N−1 resident activations raises busy and the spill request instead. The index then steps 0..15 and spill data shows the oldest activation's parameters (index 0–7) and locals (8–15). After the 16th acknowledge, busy drops and the window pointer has advanced by one.
- R8: A return with one resident activation and at least one saved raises busy and the fill request. Each acknowledged beat with index k writes fill data into entry k of the caller's window (k 0–7 parameters, 8–15 locals). After the 16th acknowledge, busy drops and the window pointer has moved back by one.
- R9: A return with one resident activation and none saved has no effect: the window pointer stays put and busy stays low.
- R10: While busy is high, call, return and the write port are ignored.
- R11: When call and return are both asserted, the call is taken.
- R12: The transfer index and spill data hold while the acknowledge is low and advance by exactly one per acknowledged beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| call_i | input | 1 | Procedure call: advance one window |
| ret_i | input | 1 | Procedure return: go back one window |
| rd_a_reg | input | 5 | Read port A logical register number |
| rd_a_data | output | 32 | Read port A data, one cycle later |
| rd_b_reg | input | 5 | Read port B logical register number |
| rd_b_data | output | 32 | Read port B data, one cycle later |
| wr_en | input | 1 | Write enable |
| wr_reg | input | 5 | Write logical register number |
| wr_data | input | 32 | Write data |
| busy | output | 1 | A spill or fill is in progress |
| cwp | output | 3 | Current window pointer |
| spill_req | output | 1 | Save request for the oldest activation |
| spill_idx | output | 4 | Register index of the current save beat |
| spill_data | output | 32 | Register value of the current save beat |
| spill_ack | input | 1 | Sequencer took the current save beat |
| fill_req | output | 1 | Restore request for the caller window |
| fill_idx | output | 4 | Register index of the current restore beat |
| fill_data | input | 32 | Restored register value |
| fill_ack | input | 1 | Fill data is valid for the current beat |

## Verification
The bench targets the seams of the overlap. If the base offset or the modulo wrap were wrong, a caller's temporaries would fail to reappear as the callee's parameters, or a window that wraps past the top of the ring would alias the wrong entries. The bench drives nesting past the N−1 limit and back below one resident activation. Spilled words are compared against the model's oldest window, and filled words must read back later as the caller's locals, so an off-by-one in the oldest-window arithmetic or in the restore target shows up as wrong data. Acknowledges are withheld at random to expose an index that slips, and call, return and write pulses are driven during a transfer to expose commands that leak through.

// File: rtl/wrf_pkg.sv
`timescale 1ns/1ps
package wrf_pkg;
  localparam int DEF_NWIN = 8;
  localparam int DEF_GRP  = 8;
  localparam int DEF_DW   = 32;

  typedef enum logic [1:0] {
    XF_IDLE  = 2'd0,
    XF_SPILL = 2'd1,
    XF_FILL  = 2'd2
  } xfer_e;
endpackage

// File: rtl/wrf_xlate.sv
`timescale 1ns/1ps
// Window-relative register number to physical location.
module wrf_xlate #(
  parameter int NWIN = wrf_pkg::DEF_NWIN,
  parameter int GRP  = wrf_pkg::DEF_GRP,
  localparam int WPW = $clog2(NWIN),
  localparam int IW  = $clog2(2 * GRP),
  localparam int GW  = $clog2(GRP),
  localparam int LRW = $clog2(4 * GRP),
  localparam int RW  = WPW + IW
) (
  input  logic [WPW-1:0] cwp,
  input  logic [LRW-1:0] lreg,
  output logic           is_glob,
  output logic [GW-1:0]  gidx,
  output logic [RW-1:0]  ridx
);
  logic [LRW-1:0] off;

  always_comb begin
    is_glob = (lreg < LRW'(GRP));
    gidx    = lreg[GW-1:0];
    off     = lreg - LRW'(GRP);
    // window base plus offset; wraps naturally because the ring is 2^RW long
    ridx    = {cwp, {IW{1'b0}}} + RW'(off);
  end
endmodule

// File: rtl/wrf_store.sv
`timescale 1ns/1ps
// Ring and global arrays; all reads registered (read-first).
module wrf_store #(
  parameter int NWIN = wrf_pkg::DEF_NWIN,
  parameter int GRP  = wrf_pkg::DEF_GRP,
  parameter int DW   = wrf_pkg::DEF_DW,
  parameter int NRD  = 2,
  localparam int WPW  = $clog2(NWIN),
  localparam int IW   = $clog2(2 * GRP),
  localparam int GW   = $clog2(GRP),
  localparam int RW   = WPW + IW,
  localparam int RING = NWIN * 2 * GRP
) (
  input  logic                    clk,
  input  logic                    ring_we,
  input  logic [RW-1:0]           ring_wa,
  input  logic [DW-1:0]           ring_wd,
  input  logic                    glob_we,
  input  logic [GW-1:0]           glob_wa,
  input  logic [DW-1:0]           glob_wd,
  input  logic [NRD-1:0]          rd_glob,
  input  logic [NRD-1:0][GW-1:0]  rd_gi,
  input  logic [NRD-1:0][RW-1:0]  rd_ri,
  output logic [NRD-1:0][DW-1:0]  rd_q,
  input  logic [RW-1:0]           sp_ra,
  output logic [DW-1:0]           sp_q
);
  logic [DW-1:0] ring [RING];
  logic [DW-1:0] glob [GRP];

  always_ff @(posedge clk) begin
    if (ring_we) ring[ring_wa] <= ring_wd;
  end

  always_ff @(posedge clk) begin
    if (glob_we) glob[glob_wa] <= glob_wd;
  end

  always_ff @(posedge clk) begin
    sp_q <= ring[sp_ra];
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    logic [DW-1:0] q;
    always_ff @(posedge clk) begin
      q <= rd_glob[p] ? glob[rd_gi[p]] : ring[rd_ri[p]];
    end
    assign rd_q[p] = q;
  end
endmodule

// File: rtl/wrf_ctrl.sv
`timescale 1ns/1ps
// Window pointer, occupancy and spill/fill sequencing.
module wrf_ctrl
  import wrf_pkg::*;
#(
  parameter int NWIN   = DEF_NWIN,
  parameter int GRP    = DEF_GRP,
  parameter int SAVE_W = 16,
  localparam int WPW = $clog2(NWIN),
  localparam int IW  = $clog2(2 * GRP),
  localparam int RW  = WPW + IW
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           call,
  input  logic           ret,
  input  logic           spill_ack,
  input  logic           fill_ack,
  output logic [WPW-1:0] cwp,
  output logic           busy,
  output logic           spill_req,
  output logic           fill_req,
  output logic [IW-1:0]  idx,
  output logic [RW-1:0]  sp_ra,
  output logic           fill_we,
  output logic [RW-1:0]  fill_wa
);
  xfer_e             state;
  logic [WPW-1:0]    res;
  logic [SAVE_W-1:0] saved;
  logic [IW-1:0]     idx_nxt;
  logic [WPW-1:0]    oldest;
  logic              full, last, ack_now;

  always_comb begin
    full    = (res == WPW'(NWIN - 1));
    last    = (idx == IW'(2 * GRP - 1));
    ack_now = (state == XF_SPILL && spill_ack) || (state == XF_FILL && fill_ack);
    oldest  = cwp - res + WPW'(1);
    if (state == XF_IDLE) idx_nxt = '0;
    else if (ack_now)     idx_nxt = last ? '0 : idx + IW'(1);
    else                  idx_nxt = idx;
    sp_ra   = {oldest, idx_nxt};
    fill_we = (state == XF_FILL) && fill_ack;
    fill_wa = {cwp - WPW'(1), idx};
  end

  assign busy      = (state != XF_IDLE);
  assign spill_req = (state == XF_SPILL);
  assign fill_req  = (state == XF_FILL);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= XF_IDLE;
      idx   <= '0;
      cwp   <= '0;
      res   <= WPW'(1);
      saved <= '0;
    end else begin
      idx <= idx_nxt;
      case (state)
        XF_IDLE: begin
          if (call) begin
            if (full) state <= XF_SPILL;
            else begin
              cwp <= cwp + WPW'(1);
              res <= res + WPW'(1);
            end
          end else if (ret) begin
            if (res != WPW'(1)) begin
              cwp <= cwp - WPW'(1);
              res <= res - WPW'(1);
            end else if (saved != '0) begin
              state <= XF_FILL;
            end
          end
        end
        XF_SPILL: if (spill_ack && last) begin
          state <= XF_IDLE;
          cwp   <= cwp + WPW'(1);
          saved <= saved + SAVE_W'(1);
        end
        XF_FILL: if (fill_ack && last) begin
          state <= XF_IDLE;
          cwp   <= cwp - WPW'(1);
          saved <= saved - SAVE_W'(1);
        end
        default: state <= XF_IDLE;
      endcase
    end
  end

  AST_RES_NONZERO: assert property (@(posedge clk) disable iff (rst)
    res != '0); // R6
  AST_SPILL_ENTRY: assert property (@(posedge clk) disable iff (rst)
    $rose(spill_req) |-> full); // R7
  AST_SPILL_DONE: assert property (@(posedge clk) disable iff (rst)
    (spill_req && spill_ack && last) |=> (!busy && cwp == $past(cwp) + WPW'(1))); // R7
  AST_FILL_ENTRY: assert property (@(posedge clk) disable iff (rst)
    $rose(fill_req) |-> (res == WPW'(1) && saved != '0)); // R8
  AST_CWP_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (busy && !(ack_now && last)) |=> $stable(cwp)); // R10
  AST_IDX_HOLD: assert property (@(posedge clk) disable iff (rst)
    (busy && !ack_now) |=> $stable(idx)); // R12
endmodule

// File: rtl/winreg_file.sv
`timescale 1ns/1ps
module winreg_file
  import wrf_pkg::*;
#(
  parameter int NWIN = DEF_NWIN,
  parameter int GRP  = DEF_GRP,
  parameter int DW   = DEF_DW,
  localparam int WPW = $clog2(NWIN),
  localparam int IW  = $clog2(2 * GRP),
  localparam int GW  = $clog2(GRP),
  localparam int LRW = $clog2(4 * GRP),
  localparam int RW  = WPW + IW,
  localparam int NRD = 2,
  localparam int NXL = NRD + 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           call_i,
  input  logic           ret_i,
  input  logic [LRW-1:0] rd_a_reg,
  output logic [DW-1:0]  rd_a_data,
  input  logic [LRW-1:0] rd_b_reg,
  output logic [DW-1:0]  rd_b_data,
  input  logic           wr_en,
  input  logic [LRW-1:0] wr_reg,
  input  logic [DW-1:0]  wr_data,
  output logic           busy,
  output logic [WPW-1:0] cwp,
  output logic           spill_req,
  output logic [IW-1:0]  spill_idx,
  output logic [DW-1:0]  spill_data,
  input  logic           spill_ack,
  output logic           fill_req,
  output logic [IW-1:0]  fill_idx,
  input  logic [DW-1:0]  fill_data,
  input  logic           fill_ack
);
  logic [NXL-1:0][LRW-1:0] lr;
  logic [NXL-1:0]          xg;
  logic [NXL-1:0][GW-1:0]  xgi;
  logic [NXL-1:0][RW-1:0]  xri;
  logic [NRD-1:0][DW-1:0]  rq;
  logic [IW-1:0]           idx;
  logic [RW-1:0]           sp_ra, fill_wa;
  logic                    fill_we, usr_we;

  assign lr = {wr_reg, rd_b_reg, rd_a_reg};

  for (genvar i = 0; i < NXL; i++) begin : g_xl
    wrf_xlate #(.NWIN(NWIN), .GRP(GRP)) u_xl (
      .cwp(cwp), .lreg(lr[i]), .is_glob(xg[i]), .gidx(xgi[i]), .ridx(xri[i])
    );
  end

  wrf_ctrl #(.NWIN(NWIN), .GRP(GRP)) u_ctrl (
    .clk(clk), .rst(rst), .call(call_i), .ret(ret_i),
    .spill_ack(spill_ack), .fill_ack(fill_ack),
    .cwp(cwp), .busy(busy), .spill_req(spill_req), .fill_req(fill_req),
    .idx(idx), .sp_ra(sp_ra), .fill_we(fill_we), .fill_wa(fill_wa)
  );

  assign usr_we = wr_en && !busy;

  wrf_store #(.NWIN(NWIN), .GRP(GRP), .DW(DW), .NRD(NRD)) u_store (
    .clk(clk),
    .ring_we(fill_we || (usr_we && !xg[NRD])),
    .ring_wa(fill_we ? fill_wa : xri[NRD]),
    .ring_wd(fill_we ? fill_data : wr_data),
    .glob_we(usr_we && xg[NRD]),
    .glob_wa(xgi[NRD]),
    .glob_wd(wr_data),
    .rd_glob(xg[NRD-1:0]),
    .rd_gi(xgi[NRD-1:0]),
    .rd_ri(xri[NRD-1:0]),
    .rd_q(rq),
    .sp_ra(sp_ra),
    .sp_q(spill_data)
  );

  assign rd_a_data = rq[0];
  assign rd_b_data = rq[1];
  assign spill_idx = idx;
  assign fill_idx  = idx;
endmodule

// File: tb/tb_winreg_file.sv
`timescale 1ns/1ps
module tb_winreg_file;
  localparam int NW = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        call_i = 0, ret_i = 0, wr_en = 0, spill_ack = 0, fill_ack = 0;
  logic [4:0]  rd_a_reg = 0, rd_b_reg = 0, wr_reg = 0;
  logic [31:0] wr_data = 0, fill_data = 0;
  logic [31:0] rd_a_data, rd_b_data, spill_data;
  logic        busy, spill_req, fill_req;
  logic [2:0]  cwp;
  logic [3:0]  spill_idx, fill_idx;

  always #4 clk = ~clk;

  winreg_file dut (
    .clk(clk), .rst(rst), .call_i(call_i), .ret_i(ret_i),
    .rd_a_reg(rd_a_reg), .rd_a_data(rd_a_data),
    .rd_b_reg(rd_b_reg), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_reg(wr_reg), .wr_data(wr_data),
    .busy(busy), .cwp(cwp),
    .spill_req(spill_req), .spill_idx(spill_idx), .spill_data(spill_data), .spill_ack(spill_ack),
    .fill_req(fill_req), .fill_idx(fill_idx), .fill_data(fill_data), .fill_ack(fill_ack)
  );

  int n_cmp = 0, n_bad = 0;
  bit disturb = 0;

  // reference model built from the requirements
  logic [31:0] mring [128];
  bit          mrv   [128];
  logic [31:0] mglob [8];
  bit          mgv   [8];
  logic [2:0]  mcwp;
  int          mres, msaved;
  logic [31:0] mem_d [64][16];
  bit          mem_v [64][16];

  function automatic logic [6:0] phys(logic [2:0] w, logic [4:0] r);
    return {w, 4'b0000} + {2'b00, r} - 7'd8;
  endfunction

  function automatic string pick(string t, string d);
    return (t == "") ? d : t;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_read(input logic [4:0] r, output logic [31:0] d, output bit v);
    if (r < 5'd8) begin d = mglob[r[2:0]]; v = mgv[r[2:0]]; end
    else begin d = mring[phys(mcwp, r)]; v = mrv[phys(mcwp, r)]; end
  endtask

  task automatic model_write(input logic [4:0] r, input logic [31:0] d);
    if (r < 5'd8) begin mglob[r[2:0]] = d; mgv[r[2:0]] = 1; end
    else begin mring[phys(mcwp, r)] = d; mrv[phys(mcwp, r)] = 1; end
  endtask

  task automatic serve_spill();
    logic [2:0] old;
    logic [3:0] kk;
    int k;
    bit ack;
    old = mcwp - 3'(mres) + 3'd1;
    k = 0;
    while (k < 16) begin
      kk = k[3:0];
      check("R7", {31'b0, spill_req}, 32'd1);
      check("R12", {28'b0, spill_idx}, k);
      if (mrv[{old, kk}]) check("R7", spill_data, mring[{old, kk}]);
      mem_d[msaved][k] = mring[{old, kk}];
      mem_v[msaved][k] = mrv[{old, kk}];
      ack = ($urandom_range(0, 3) != 0);
      spill_ack = ack;
      if (disturb) begin
        wr_en = 1; wr_reg = 5'd5; wr_data = $urandom;
        call_i = 1'($urandom_range(0, 1)); ret_i = 1'($urandom_range(0, 1));
      end
      @(negedge clk);
      spill_ack = 0; wr_en = 0; call_i = 0; ret_i = 0;
      if (ack) k++;
    end
    msaved++;
    mcwp = mcwp + 3'd1;
    check("R7", {31'b0, busy}, 32'd0);
    check("R7,R10", {29'b0, cwp}, {29'b0, mcwp});
  endtask

  task automatic serve_fill();
    logic [2:0] win;
    logic [3:0] kk;
    int k, top;
    bit ack;
    win = mcwp - 3'd1;
    top = msaved - 1;
    k = 0;
    while (k < 16) begin
      kk = k[3:0];
      check("R8", {31'b0, fill_req}, 32'd1);
      check("R12", {28'b0, fill_idx}, k);
      ack = ($urandom_range(0, 3) != 0);
      fill_ack = ack;
      fill_data = mem_d[top][k];
      @(negedge clk);
      fill_ack = 0;
      if (ack) begin
        mring[{win, kk}] = mem_d[top][k];
        mrv[{win, kk}] = mem_v[top][k];
        k++;
      end
    end
    msaved--;
    mcwp = mcwp - 3'd1;
    check("R8", {31'b0, busy}, 32'd0);
    check("R8", {29'b0, cwp}, {29'b0, mcwp});
  endtask

  // one command cycle; called at a falling edge
  task automatic cyc(input bit c, input bit r, input bit w, input logic [4:0] wa,
                     input logic [31:0] wd, input logic [4:0] a, input logic [4:0] b,
                     input string tag);
    logic [31:0] ea, eb;
    bit va, vb, dsp, dfl;
    model_read(a, ea, va);
    model_read(b, eb, vb);
    call_i = c; ret_i = r; wr_en = w; wr_reg = wa; wr_data = wd;
    rd_a_reg = a; rd_b_reg = b;
    if (w) model_write(wa, wd);
    dsp = 0; dfl = 0;
    if (c) begin
      if (mres == NW - 1) dsp = 1;
      else begin mcwp = mcwp + 3'd1; mres++; end
    end else if (r) begin
      if (mres > 1) begin mcwp = mcwp - 3'd1; mres--; end
      else if (msaved > 0) dfl = 1;
    end
    @(negedge clk);
    check(pick(tag, "R6"), {29'b0, cwp}, {29'b0, mcwp});
    check(dsp ? "R7" : dfl ? "R8" : pick(tag, "R6"), {31'b0, busy}, {31'b0, dsp | dfl});
    if (va) check(pick(tag, (a < 5'd8) ? "R1" : "R2"), rd_a_data, ea);
    if (vb) check(pick(tag, (b < 5'd8) ? "R1" : "R2"), rd_b_data, eb);
    call_i = 0; ret_i = 0; wr_en = 0;
    if (dsp) serve_spill();
    if (dfl) serve_fill();
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog: got hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < 128; i++) mrv[i] = 0;
    for (int i = 0; i < 8; i++) mgv[i] = 0;
    mcwp = 0; mres = 1; msaved = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    // R5 reset state
    check("R5", {29'b0, cwp}, 32'd0);
    check("R5", {31'b0, busy}, 32'd0);
    check("R5", {31'b0, spill_req}, 32'd0);
    check("R5", {31'b0, fill_req}, 32'd0);

    cyc(0, 1, 0, 0, 0, 0, 0, "R9");                    // return at the bottom
    cyc(0, 0, 1, 5'd2, 32'hA2A2_0002, 0, 0, "");
    cyc(0, 0, 1, 5'd24, 32'hC0C0_0024, 0, 0, "");
    cyc(0, 0, 1, 5'd16, 32'hAAAA_0016, 0, 0, "");
    cyc(0, 0, 1, 5'd9, 32'h0000_0099, 0, 0, "");
    cyc(0, 0, 1, 5'd9, 32'h1234_5678, 5'd9, 5'd2, "R4"); // read-first
    cyc(0, 0, 0, 0, 0, 5'd9, 5'd9, "R4");
    cyc(1, 0, 0, 0, 0, 0, 0, "");
    cyc(0, 0, 0, 0, 0, 5'd8, 5'd8, "R2");             // caller temp = callee param
    cyc(0, 0, 0, 0, 0, 5'd2, 5'd2, "R1");
    cyc(0, 0, 1, 5'd8, 32'hD0D0_0008, 0, 0, "");
    cyc(0, 0, 1, 5'd16, 32'hBBBB_0016, 0, 0, "");
    cyc(0, 1, 0, 0, 0, 0, 0, "");
    cyc(0, 0, 0, 0, 0, 5'd24, 5'd24, "R2");
    cyc(0, 0, 0, 0, 0, 5'd16, 5'd16, "R3");
    cyc(1, 1, 0, 0, 0, 0, 0, "R11");
    cyc(0, 0, 1, 5'd5, 32'h0000_0055, 0, 0, "");
    while (mres < NW - 1) cyc(1, 0, 0, 0, 0, 0, 0, "");
    disturb = 1;
    cyc(1, 0, 0, 0, 0, 0, 0, "R7");
    disturb = 0;
    cyc(0, 0, 0, 0, 0, 5'd5, 5'd5, "R10");
    cyc(0, 0, 0, 0, 0, 5'd2, 5'd2, "R1");
    for (int i = 0; i < 3; i++) cyc(1, 0, 0, 0, 0, 0, 0, "");
    for (int i = 0; i < 12; i++) cyc(0, 1, 0, 0, 0, 0, 0, "");
    cyc(0, 0, 0, 0, 0, 5'd16, 5'd24, "");

    for (int i = 0; i < 2500; i++) begin
      bit c, r, w;
      logic [4:0] wa, a, b;
      c = ($urandom_range(0, 99) < 20) && (msaved < 60);
      r = ($urandom_range(0, 99) < 20);
      w = ($urandom_range(0, 1) == 1);
      wa = 5'($urandom_range(0, 31));
      a = 5'($urandom_range(0, 31));
      b = 5'($urandom_range(0, 31));
      cyc(c, r, w, wa, $urandom, a, b, "");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule